// File: doc/BRIEF.md
# Millisecond Real-Time Clock with Shadowed Seconds

This block is a free-running real-time clock kept by a slow always-on time base. A one-cycle `tick_en` strobe stands in for that time base. Each strobe advances a millisecond count. When the count wraps, a seconds count advances in the same cycle. Because the counters have no enable other than the tick, they keep counting through any power-management state that leaves the block clocked. This lets the block serve as a persistent time source.

Software reads the clock through a small read-only register bus. It sees three registers, at byte offsets fixed by the software that decodes them: live seconds at 0x08, shadow seconds at 0x0C and milliseconds at 0x10.

A timestamp that cannot tear is taken with two reads:
- First, read the milliseconds register. That read also copies the seconds value into the shadow register.
- Second, read the shadow register.
- Combine the two as seconds × MS_PER_SEC + milliseconds.

Only one such read pair may be in flight at a time, because the shadow register is shared.

Top module: `rtc_shadow_top`

## Requirements
- R1: A synchronous active-high reset clears milliseconds, live seconds and shadow seconds to zero, and holds `rd_valid` low.
- R2: The millisecond count rises by one at each clock edge where `tick_en` is high, and holds its value when `tick_en` is low.
- R3: On a tick when the millisecond count is MS_PER_SEC-1, it returns to 0 and live seconds rises by one at that same edge.
- R4: Live seconds is SEC_W bits wide and wraps silently from 2^SEC_W-1 to 0.
- R5: A read (`rd_en` high) returns its data on `rd_data` one cycle later, with `rd_valid` high for exactly that cycle. `rd_valid` is low after any cycle without a read. Register values read are those held before the edge that accepts the read.
- R6: A read at offset 0x10 returns milliseconds and loads shadow seconds with the seconds value paired with the returned milliseconds. This holds even when a rollover happens at the same edge. Shadow × MS_PER_SEC + milliseconds then equals the number of ticks before that read, modulo MS_PER_SEC × 2^SEC_W.
- R7: A read at offset 0x0C returns shadow seconds. A read at offset 0x08 returns live seconds. Neither of these reads changes the shadow.
- R8: A read at any other offset returns zero.
- R9: Reads never stall or disturb the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-millisecond time-base strobe |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte offset of the register read |
| rd_data | output | DATA_W | Registered read data, zero-extended |
| rd_valid | output | 1 | High in the cycle `rd_data` is valid |

## Verification
Every read result is due one clock edge after the cycle that presents the read. The bench drives inputs on the falling edge, lets one rising edge pass, and samples `rd_data` and `rd_valid` on the next falling edge. Counter and shadow effects are also due one edge after the tick or read that causes them. The bench model therefore computes each read's expected value from its state before that edge, and only then advances the model. The bench uses five milliseconds per second and four-bit seconds, so the sweeps cross every rollover, the seconds wrap, and reads that coincide with a rollover.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

  // Byte offsets decoded by software; their values are fixed.
  localparam logic [7:0] OFS_SEC_LIVE   = 8'h08;
  localparam logic [7:0] OFS_SEC_SHADOW = 8'h0C;
  localparam logic [7:0] OFS_MSEC       = 8'h10;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_LIVE   = 2'd1,
    SEL_SHADOW = 2'd2,
    SEL_MSEC   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/rtc_ms_count.sv
module rtc_ms_count #(
  parameter int MS_PER_SEC = 1000,
  localparam int MS_W = $clog2(MS_PER_SEC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  output logic [MS_W-1:0] ms,
  output logic            roll
);

  localparam logic [MS_W-1:0] LAST = MS_W'(MS_PER_SEC - 1);

  assign roll = tick && (ms == LAST);

  always_ff @(posedge clk) begin
    if (rst)       ms <= '0;
    else if (roll) ms <= '0;
    else if (tick) ms <= ms + 1'b1;
  end

  assert_ms_range_R3: assert property (@(posedge clk) disable iff (rst)
    ms <= LAST);
  assert_ms_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && ms != LAST) |=> ms == $past(ms) + 1'b1);
  assert_ms_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(ms));
  assert_ms_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && ms == LAST) |=> ms == '0);

endmodule

// File: rtl/rtc_sec_count.sv
module rtc_sec_count #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             carry,
  input  logic             snap,
  output logic [SEC_W-1:0] sec,
  output logic [SEC_W-1:0] shadow
);

  always_ff @(posedge clk) begin
    if (rst)        sec <= '0;
    else if (carry) sec <= sec + 1'b1;
  end

  // Captures the pre-edge value, which pairs with the pre-edge ms returned.
  always_ff @(posedge clk) begin
    if (rst)       shadow <= '0;
    else if (snap) shadow <= sec;
  end

  assert_sec_carry_R3: assert property (@(posedge clk) disable iff (rst)
    carry |=> sec == $past(sec) + 1'b1);
  assert_sec_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !carry |=> $stable(sec));
  assert_shadow_load_R6: assert property (@(posedge clk) disable iff (rst)
    snap |=> shadow == $past(sec));
  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !snap |=> $stable(shadow));

endmodule

// File: rtl/rtc_read_port.sv
module rtc_read_port
  import rtc_shadow_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int MS_W   = 10,
  parameter int SEC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [MS_W-1:0]   ms,
  input  logic [SEC_W-1:0]  sec,
  input  logic [SEC_W-1:0]  shadow,
  output logic              snap,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  reg_sel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if (rd_addr == ADDR_W'(OFS_SEC_LIVE))        sel = SEL_LIVE;
    else if (rd_addr == ADDR_W'(OFS_SEC_SHADOW)) sel = SEL_SHADOW;
    else if (rd_addr == ADDR_W'(OFS_MSEC))       sel = SEL_MSEC;
  end

  assign snap = rd_en && (sel == SEL_MSEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (sel)
          SEL_LIVE:   rd_data <= DATA_W'(sec);
          SEL_SHADOW: rd_data <= DATA_W'(shadow);
          SEL_MSEC:   rd_data <= DATA_W'(ms);
          default:    rd_data <= '0;
        endcase
      end
    end
  end

  assert_valid_rise_R5: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_valid_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_NONE) |=> rd_data == '0);

endmodule

// File: rtl/rtc_shadow_top.sv
module rtc_shadow_top #(
  parameter int MS_PER_SEC = 1000,
  parameter int SEC_W      = 32,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int MS_W = $clog2(MS_PER_SEC);

  logic [MS_W-1:0]  ms;
  logic             roll;
  logic             snap;
  logic [SEC_W-1:0] sec;
  logic [SEC_W-1:0] shadow;

  rtc_ms_count #(.MS_PER_SEC(MS_PER_SEC)) u_ms (
    .clk(clk), .rst(rst), .tick(tick_en), .ms(ms), .roll(roll)
  );

  rtc_sec_count #(.SEC_W(SEC_W)) u_sec (
    .clk(clk), .rst(rst), .carry(roll), .snap(snap),
    .sec(sec), .shadow(shadow)
  );

  rtc_read_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MS_W(MS_W), .SEC_W(SEC_W)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .ms(ms), .sec(sec), .shadow(shadow), .snap(snap),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ms == '0 && sec == '0 && shadow == '0 && !rd_valid));

endmodule

// File: tb/test_rtc_shadow_top.sv
module test_rtc_shadow_top;
  localparam int MSPS = 5;
  localparam int SW   = 4;
  localparam int AW   = 8;
  localparam int DW   = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int checks = 0;
  int errors = 0;
  int exp_ms = 0, exp_sec = 0, exp_sh = 0;
  int total_ticks = 0;

  always #2 clk = ~clk;

  rtc_shadow_top #(.MS_PER_SEC(MSPS), .SEC_W(SW), .ADDR_W(AW), .DATA_W(DW)) i_rtc_shadow_top (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge; presents one cycle of stimulus and checks it.
  task automatic cyc(bit t, bit r, logic [7:0] a, string tag);
    int e;
    e = 0;
    if (r) begin
      case (a)
        8'h08:   e = exp_sec;
        8'h0C:   e = exp_sh;
        8'h10:   e = exp_ms;
        default: e = 0;
      endcase
    end
    if (r && a == 8'h10) exp_sh = exp_sec;
    if (t) begin
      total_ticks++;
      if (exp_ms == MSPS - 1) begin
        exp_ms = 0;
        exp_sec = (exp_sec + 1) % (1 << SW);
      end else exp_ms++;
    end
    tick_en = t; rd_en = r; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0; rd_en = 1'b0;
    chk("R5 rd_valid", rd_valid, r);
    if (r) chk(tag, rd_data, e);
  endtask

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h10:   return "R2/R3 ms during ticks (R9)";
      8'h0C:   return "R6 shadow";
      8'h08:   return "R7 live seconds";
      default: return "R8 unmapped";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] addrs [4];
    int got_ms, ts;
    addrs[0] = 8'h08; addrs[1] = 8'h10; addrs[2] = 8'h0C; addrs[3] = 8'h04;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 rd_valid after reset", rd_valid, 0);
    cyc(0, 1, 8'h08, "R1 live seconds");
    cyc(0, 1, 8'h0C, "R1 shadow");
    cyc(0, 1, 8'h10, "R1 ms");

    // Sweep: tick every cycle, rotate reads across all offsets.
    for (int i = 0; i < 100; i++) cyc(1, 1, addrs[i % 4], tag_of(addrs[i % 4]));
    cyc(0, 1, 8'h08, "R4 seconds wrap");
    chk("R4 seconds after 100 ticks", exp_sec, (100 / MSPS) % (1 << SW));

    // No tick: ms must hold.
    cyc(0, 1, 8'h10, "R2 hold");
    cyc(0, 1, 8'h10, "R2 hold");

    // Shadow unaffected by live reads and other offsets.
    cyc(0, 1, 8'h10, "R6 snapshot");
    for (int i = 0; i < 12; i++) cyc(1, 0, 8'h00, "");
    cyc(0, 1, 8'h08, "R7 live moved");
    cyc(0, 1, 8'h14, "R8 unmapped");
    cyc(0, 1, 8'h0C, "R7 shadow unchanged");

    // Paired reads against an arithmetic tick count.
    for (int k = 0; k < 40; k++) begin
      ts = total_ticks % (MSPS << SW);
      cyc(k % 2, 1, 8'h10, "R6 ms of pair");
      got_ms = int'(rd_data);
      cyc(k % 3 == 0, 1, 8'h0C, "R6 shadow of pair");
      chk("R6 timestamp", int'(rd_data) * MSPS + got_ms, ts);
    end

    // Read that coincides with rollover.
    while (exp_ms != MSPS - 1) cyc(1, 0, 8'h00, "");
    ts = total_ticks % (MSPS << SW);
    cyc(1, 1, 8'h10, "R3 ms at rollover");
    got_ms = int'(rd_data);
    cyc(0, 1, 8'h0C, "R6 shadow at rollover");
    chk("R6 timestamp at rollover", int'(rd_data) * MSPS + got_ms, ts);
    cyc(0, 1, 8'h10, "R3 ms after rollover");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule